// File: doc/BRIEF.md
# Key-Protected SDRAM Configuration Register Bank

This block holds the software-visible configuration words of an SDRAM controller. It sits behind a 32-bit word-access request channel and a read-response channel. Each request carries a byte address inside a 4 KB window. The register slot is the byte address shifted right by two, so the two low address bits are ignored. A write changes storage on the edge where the request is accepted. An accepted read returns one response beat on the response channel. An accepted write returns no response.

Slot 0 is a guard word, and software may always write it. Every other slot is changed only while the guard word holds exactly 0xFC600309. Writing any other value to the guard word closes the bank again.

Slot 1 is the configuration word. Its read-only bits depend on a static layout-select input. Its reset value encodes the attached memory size, which comes from a static input sampled while reset is asserted. The controller itself does not use the configuration fields: they are stored and driven out on a port, together with an open/closed status.

The request channel follows valid/ready rules. A request is accepted on a rising edge where both `req_valid` and `req_ready` are high, and the requester must hold its fields stable until then. The bank holds one response slot. `req_ready` is low while a read response is waiting, so a consumer that keeps `rsp_ready` low stalls the request side as well. A pending response keeps `rsp_valid` high and `rsp_rdata` unchanged until the response is accepted.

Top module: `keyed_cfg_bank`

## Requirements
- R1: Reset (rst_n low on a rising edge) clears every slot to zero, except the configuration word, and closes the bank (`bank_open` = 0).
- R2: A write to slot 0 is always stored, whatever the lock state. `bank_open` is 1 exactly while slot 0 holds 0xFC600309.
- R3: While the bank is closed, a write to any slot other than 0 leaves that slot unchanged.
- R4: Writing any value other than 0xFC600309 to slot 0 closes the bank, and later writes to other slots are dropped.
- R5: With `layout_sel` = 0, a write to slot 1 leaves bits 31:11, bit 6 and bits 3:2 at their current values and stores the written data in all other bits.
- R6: With `layout_sel` = 1, a write to slot 1 leaves bits 31:28, bits 19:14, bit 6 and bits 3:2 at their current values and stores the written data in all other bits.
- R7: Reset value of slot 1.
  - With `layout_sel` = 0, the value is 0x40 plus a size code in bits 1:0: 64 MB=0, 128 MB=1, 256 MB=2, 512 MB=3.
  - With `layout_sel` = 1, the value is 0x1000000C plus a size code in bits 1:0: 128 MB=0, 256 MB=1, 512 MB=2, 1024 MB=3.
  - Any other `mem_mb` value gives size code 0.
- R8: A read of a slot index at or above NREGS (default 32) returns 0. A write to such an index changes no slot.
- R9: The slot index is `req_addr[11:2]`, and `req_addr[1:0]` have no effect.
- R10: The response channel behaves as follows.
  - Each accepted read yields exactly one response beat, carrying the slot contents at acceptance.
  - A write yields no beat.
  - While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold and `req_ready` is low.
- R11: Reads have no side effect: reading slot 0 returns its stored value and leaves the lock state unchanged.
- R12: `cfg_word` always shows the current contents of slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| layout_sel | input | 1 | Static layout select: 0 or 1 |
| mem_mb | input | 16 | Static attached memory size in MB, sampled during reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the 4 KB window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_rdata | output | 32 | Read response data |
| cfg_word | output | 32 | Current configuration word (slot 1) |
| bank_open | output | 1 | 1 while slot 0 holds the unlock key |

## Verification
The bench writes all-ones and then all-zeros into the configuration word under both layouts. A mask with a wrong bit either lets a protected field change or freezes a writable one. The bench also tries writes while the bank is closed, and again after the key has been replaced. A missing gate or a missing relock would show up as a changed slot.

Reset is repeated across every supported size and several unsupported sizes. These runs expose a wrong size code, a wrong fallback, or a default that ignores the layout.

Out-of-range indices are aimed at addresses that would alias onto slots 0 and 1 if the index were truncated. Other requests set the two low address bits. A stalled response is held for several cycles, which would expose a response slot that drops or overwrites data.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

  localparam logic [31:0] UNLOCK_KEY = 32'hFC60_0309;

  typedef enum logic {
    LAYOUT_A = 1'b0,
    LAYOUT_B = 1'b1
  } layout_e;

  // Read-only fields of the configuration word
  localparam logic [31:0] RO_A_RESV   = 32'hFFFF_F800;
  localparam logic [31:0] RO_B_HWVER  = 32'hF000_0000;
  localparam logic [31:0] RO_B_INITOK = 32'h0008_0000;
  localparam logic [31:0] RO_B_RESV   = 32'h0007_C000;
  localparam logic [31:0] RO_COMPAT   = 32'h0000_0040;
  localparam logic [31:0] RO_APERTURE = 32'h0000_000C;

  // Reset defaults other than the size code
  localparam logic [31:0] DEF_A = 32'h0000_0040;
  localparam logic [31:0] DEF_B = 32'h1000_000C;

  // Smallest supported size per layout, in MB
  localparam int unsigned BASE_MB_A = 64;
  localparam int unsigned BASE_MB_B = 128;
  localparam int unsigned SIZE_CODES = 4;

  function automatic logic [31:0] ro_mask(layout_e l);
    if (l == LAYOUT_B)
      return RO_B_HWVER | RO_B_INITOK | RO_B_RESV | RO_COMPAT | RO_APERTURE;
    return RO_A_RESV | RO_COMPAT | RO_APERTURE;
  endfunction

  function automatic logic [31:0] reset_cfg(layout_e l, logic [1:0] code);
    return ((l == LAYOUT_B) ? DEF_B : DEF_A) | {30'd0, code};
  endfunction

endpackage

// File: rtl/keyed_cfg_sizer.sv
module keyed_cfg_sizer
  import keyed_cfg_pkg::*;
#(
  parameter int MB_W = 16
) (
  input  layout_e          layout,
  input  logic [MB_W-1:0]  mem_mb,
  output logic [1:0]       size_code
);
  localparam int unsigned CODES = SIZE_CODES;

  logic [CODES-1:0] hit;

  for (genvar k = 0; k < CODES; k++) begin : g_code
    localparam int unsigned MB_A = BASE_MB_A << k;
    localparam int unsigned MB_B = BASE_MB_B << k;
    always_comb begin
      if (layout == LAYOUT_B) hit[k] = (32'(mem_mb) == MB_B);
      else                    hit[k] = (32'(mem_mb) == MB_A);
    end
  end

  // Unsupported sizes match nothing and fall back to code 0
  always_comb begin
    size_code = 2'd0;
    for (int k = 0; k < CODES; k++)
      if (hit[k]) size_code = 2'(k);
  end

  always_comb begin
    assert ($onehot0(hit)) else $error("a_r7_single_size_match");
  end
endmodule

// File: rtl/keyed_cfg_store.sv
module keyed_cfg_store
  import keyed_cfg_pkg::*;
#(
  parameter int NREGS  = 32,
  parameter int SLOT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  layout_e           layout,
  input  logic [1:0]        size_code,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [31:0]       wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [31:0]       rd_data,
  output logic [31:0]       cfg_q,
  output logic              unlocked
);
  localparam int GUARD = 0;
  localparam int CFG   = 1;

  logic [31:0] guard_q;
  logic [31:0] slot_val [NREGS];
  logic [31:0] ro;

  assign ro       = ro_mask(layout);
  assign unlocked = (guard_q == UNLOCK_KEY);

  // Guard word: always writable
  always_ff @(posedge clk) begin
    if (!rst_n)                                   guard_q <= '0;
    else if (wr_en && wr_slot == SLOT_W'(GUARD))  guard_q <= wr_data;
  end

  // Configuration word: gated, read-only bits kept
  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg_q <= reset_cfg(layout, size_code);
    else if (wr_en && unlocked && wr_slot == SLOT_W'(CFG))
      cfg_q <= (cfg_q & ro) | (wr_data & ~ro);
  end

  assign slot_val[GUARD] = guard_q;
  assign slot_val[CFG]   = cfg_q;

  // Plain storage slots
  for (genvar i = 2; i < NREGS; i++) begin : g_slot
    logic [31:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                       q <= '0;
      else if (wr_en && unlocked && wr_slot == SLOT_W'(i)) q <= wr_data;
    end
    assign slot_val[i] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++)
      if (rd_slot == SLOT_W'(i)) rd_data = slot_val[i];
  end

  a_r3_cfg_closed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked && wr_slot == SLOT_W'(CFG)) |=> $stable(cfg_q));

  a_r5_r6_ro_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot == SLOT_W'(CFG)) |=> ((cfg_q & ro) == ($past(cfg_q) & ro)));

  a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_slot == SLOT_W'(GUARD)) |=> (unlocked == ($past(wr_data) == UNLOCK_KEY)));

  a_r4_open_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_slot == SLOT_W'(GUARD)) |=> $stable(unlocked));
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port #(
  parameter int NREGS  = 32,
  parameter int ADDR_W = 12,
  parameter int SLOT_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              wr_en,
  output logic [SLOT_W-1:0] slot,
  input  logic [31:0]       rd_data
);
  logic accept;
  logic in_range;
  logic unused_lsb;

  assign unused_lsb = ^req_addr[1:0];
  assign slot       = req_addr[ADDR_W-1:2];
  assign in_range   = (32'(slot) < NREGS);
  assign req_ready  = !rsp_valid;
  assign accept     = req_valid && req_ready;
  assign wr_en      = accept && req_write && in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= in_range ? rd_data : '0;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r10_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r10_write_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> !rsp_valid);

  a_r8_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && 32'(req_addr[ADDR_W-1:2]) >= NREGS)
      |=> (rsp_valid && rsp_rdata == 32'd0));
endmodule

// File: rtl/keyed_cfg_bank.sv
module keyed_cfg_bank
  import keyed_cfg_pkg::*;
#(
  parameter int NREGS  = 32,
  parameter int ADDR_W = 12,
  parameter int MB_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              layout_sel,
  input  logic [MB_W-1:0]   mem_mb,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic [31:0]       cfg_word,
  output logic              bank_open
);
  localparam int SLOT_W = ADDR_W - 2;

  layout_e           layout;
  logic [1:0]        size_code;
  logic              wr_en;
  logic [SLOT_W-1:0] slot;
  logic [31:0]       rd_data;

  assign layout = layout_e'(layout_sel);

  keyed_cfg_sizer #(.MB_W(MB_W)) u_sizer (
    .layout    (layout),
    .mem_mb    (mem_mb),
    .size_code (size_code)
  );

  keyed_cfg_port #(.NREGS(NREGS), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .wr_en     (wr_en),
    .slot      (slot),
    .rd_data   (rd_data)
  );

  keyed_cfg_store #(.NREGS(NREGS), .SLOT_W(SLOT_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .layout    (layout),
    .size_code (size_code),
    .wr_en     (wr_en),
    .wr_slot   (slot),
    .wr_data   (req_wdata),
    .rd_slot   (slot),
    .rd_data   (rd_data),
    .cfg_q     (cfg_word),
    .unlocked  (bank_open)
  );
endmodule

// File: tb/keyed_cfg_bank_test.sv
module keyed_cfg_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        layout_sel = 1'b0;
  logic [15:0] mem_mb = 16'd64;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [31:0] cfg_word;
  logic        bank_open;

  localparam logic [31:0] KEY = 32'hFC60_0309;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  keyed_cfg_bank uut (
    .clk(clk), .rst_n(rst_n), .layout_sel(layout_sel), .mem_mb(mem_mb),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .cfg_word(cfg_word),
    .bank_open(bank_open)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pop expected read data as each response beat is taken
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10: actual unexpected beat %h expected none", rsp_rdata);
      end else begin
        check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic issue(bit wr, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    issue(1'b1, a, d);
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    issue(1'b0, a, 32'd0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  task automatic do_reset(bit lay, logic [15:0] mb);
    @(negedge clk);
    layout_sel = lay; mem_mb = mb; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1 / R7: reset state, layout A 512 MB
    do_reset(1'b0, 16'd512);
    check("R1 bank closed", {31'd0, bank_open}, 32'd0);
    check("R7 A 512MB", cfg_word, 32'h43);
    check("R10 no beat idle", {31'd0, rsp_valid}, 32'd0);
    rd(12'h008, 32'd0, "R1 slot2 zero");
    rd(12'h000, 32'd0, "R1 guard zero");

    // R3: closed bank drops writes
    wr(12'h008, 32'hA5A5_5A5A);
    wr(12'h004, 32'h0000_0000);
    rd(12'h008, 32'd0, "R3 slot2 dropped");
    check("R3 cfg unchanged", cfg_word, 32'h43);

    // R2: key opens
    wr(12'h000, KEY);
    check("R2 bank open", {31'd0, bank_open}, 32'd1);
    rd(12'h000, KEY, "R11 guard readable");
    check("R11 still open after read", {31'd0, bank_open}, 32'd1);

    // R5: layout A mask
    wr(12'h004, 32'hFFFF_FFFF);
    check("R5 A all ones", cfg_word, 32'h0000_07F3);
    rd(12'h004, 32'h0000_07F3, "R12 cfg readback");
    wr(12'h004, 32'h0000_0000);
    check("R5 A all zeros", cfg_word, 32'h0000_0040);

    // R9: low address bits ignored
    wr(12'h00B, 32'h1234_5678);
    rd(12'h008, 32'h1234_5678, "R9 lsb ignored write");
    rd(12'h07E, 32'd0, "R9 slot31 via lsb");
    wr(12'h07C, 32'hCAFE_0031);
    rd(12'h07D, 32'hCAFE_0031, "R9 last slot");

    // R8: out of range, aliases of slots 0 and 1
    rd(12'h080, 32'd0, "R8 oob read");
    wr(12'h080, 32'h0000_0000);
    wr(12'h084, 32'hFFFF_FFFF);
    check("R8 guard not aliased", {31'd0, bank_open}, 32'd1);
    check("R8 cfg not aliased", cfg_word, 32'h0000_0040);
    rd(12'hFFC, 32'd0, "R8 top of window");

    // R10: back-pressure
    drain();
    @(negedge clk); rsp_ready = 1'b0;
    issue(1'b0, 12'h008, 32'd0);
    exp_q.push_back(32'h1234_5678); tag_q.push_back("R10 held beat");
    repeat (3) begin
      @(negedge clk);
      check("R10 valid held", {31'd0, rsp_valid}, 32'd1);
      check("R10 data held", rsp_rdata, 32'h1234_5678);
      check("R10 ready low", {31'd0, req_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    drain();
    wr(12'h010, 32'h5);
    check("R10 write no beat", {31'd0, rsp_valid}, 32'd0);

    // R4: relock
    wr(12'h000, KEY ^ 32'h1);
    check("R4 closed", {31'd0, bank_open}, 32'd0);
    wr(12'h008, 32'hDEAD_BEEF);
    rd(12'h008, 32'h1234_5678, "R4 write dropped");
    wr(12'h000, KEY);
    check("R2 reopen", {31'd0, bank_open}, 32'd1);

    // R6 / R7: layout B
    do_reset(1'b1, 16'd1024);
    check("R7 B 1024MB", cfg_word, 32'h1000_000F);
    rd(12'h008, 32'd0, "R1 B slot2 zero");
    wr(12'h000, KEY);
    wr(12'h004, 32'hFFFF_FFFF);
    check("R6 B all ones", cfg_word, 32'h1FF0_3FBF);
    wr(12'h004, 32'h0000_0000);
    check("R6 B all zeros", cfg_word, 32'h1000_000C);

    // R7: size table and fallback
    do_reset(1'b0, 16'd64);   check("R7 A 64MB",  cfg_word, 32'h40);
    do_reset(1'b0, 16'd128);  check("R7 A 128MB", cfg_word, 32'h41);
    do_reset(1'b0, 16'd256);  check("R7 A 256MB", cfg_word, 32'h42);
    do_reset(1'b0, 16'd1024); check("R7 A unsupported", cfg_word, 32'h40);
    do_reset(1'b0, 16'd100);  check("R7 A odd size", cfg_word, 32'h40);
    do_reset(1'b1, 16'd128);  check("R7 B 128MB", cfg_word, 32'h1000_000C);
    do_reset(1'b1, 16'd256);  check("R7 B 256MB", cfg_word, 32'h1000_000D);
    do_reset(1'b1, 16'd512);  check("R7 B 512MB", cfg_word, 32'h1000_000E);
    do_reset(1'b1, 16'd64);   check("R7 B unsupported", cfg_word, 32'h1000_000C);
    check("R1 closed after reset", {31'd0, bank_open}, 32'd0);

    drain();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule